// File: doc/BRIEF.md
# Private System Register Space Router

This block sits in front of the 1 MB private system register window that begins at 0xE000_0000. Each request carries a 20-bit offset into that window, a read/write flag, write data, a privilege bit and a security bit. The block picks one target for the request. The targets are the system-control/interrupt register block, a non-secure timer block, a secure timer block and a reliability register block. If no target claims the offset, a built-in default responder answers. The winning target gets a one-cycle strobe with a 12-bit local offset and the attributes, which may be rewritten. The target returns read data in that same cycle. One cycle later the block returns read data and a fault flag.

Regions overlap, and the smaller, higher-priority region wins. The timer window sits inside the system-control page. The reliability block and the system-control page sit inside the default space. A second page at offset 0x2E000 is a non-secure alias. A secure caller uses it to reach the non-secure view of the system-control page and of the timer. A non-secure caller gets the default behaviour there.

Both sides of the block use valid/ready handshakes. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is waiting, or the waiting response is being taken in the same cycle. An un-taken response stays valid and unchanged. Two parameters set the optional parts. `SEC_EXT` enables the alias page and the secure timer. `RAS_EN` enables the reliability block. A disabled part's addresses fall to the default responder.

Top module: `sysreg_router`

## Requirements
- R1: The default responder covers every offset not claimed by another region. A privileged access to it returns read data 0 with no fault, and it raises no target strobe, so a write there changes nothing.
- R2: An unprivileged access to the default responder returns `rsp_fault` = 1, with read data 0.
- R3: Offsets 0x0E000 to 0x0EFFF select the system-control block (`tgt_sel` bit 0), except for the timer window. Privilege does not matter.
- R4: Offsets 0x0E010 to 0x0E0EF select a timer, and this overrides the system-control block. Offsets 0x0E00C and 0x0E0F0 stay with the system-control block.
- R5: A timer access with the security bit set goes to the secure timer (`tgt_sel` bit 2). With the bit clear it goes to the non-secure timer (`tgt_sel` bit 1). The target sees `tgt_secure` equal to the attribute used for the choice.
- R6: A secure access to the alias page (0x2E000 to 0x2EFFF) is forwarded as if it were at the same local offset in page 0x0E000, with `tgt_secure` cleared. An alias timer offset therefore reaches the non-secure timer.
- R7: A non-secure access to the alias page gets the default behaviour. That means read-as-zero and ignored writes when privileged, and a fault when unprivileged.
- R8: Offsets 0x05000 to 0x05FFF select the reliability block (`tgt_sel` bit 3) with priority over the default responder. Offsets 0x04FFC and 0x06000 fall to the default.
- R9: For each accepted request, exactly one target is chosen, counting the default responder. `tgt_sel` is all zero in any cycle without an accept. `tgt_addr` is the low 12 offset bits. `tgt_write` and `tgt_wdata` follow the request.
- R10: The response is valid in the cycle after an accept. Its read data is the chosen target's `tgt_rdata` slice (target n at bits [32n+31:32n]) as seen in the accept cycle.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, no strobe is raised, and the response is held unchanged. The response drops after it has been taken, if no new request is accepted.
- R12: After reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | 20 | Byte offset into the system register window |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_priv | input | 1 | 1 = privileged access |
| req_secure | input | 1 | 1 = secure access |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken this cycle |
| rsp_rdata | output | 32 | Read data (0 for default responder) |
| rsp_fault | output | 1 | Access faulted |
| tgt_sel | output | 4 | One-hot target strobe: 0 control, 1 timer NS, 2 timer S, 3 reliability |
| tgt_addr | output | 12 | Local offset inside the target |
| tgt_write | output | 1 | Write flag to target |
| tgt_wdata | output | 32 | Write data to target |
| tgt_secure | output | 1 | Security attribute after alias rewriting |
| tgt_priv | output | 1 | Privilege attribute to target |
| tgt_rdata | input | 128 | Read data from the four targets, 32 bits each |

## Verification
The routing is tried with offsets placed on both sides of every region edge. These are 0x0E00C/0x0E010 and 0x0E0EF/0x0E0F0 for the timer, 0x04FFC/0x05004/0x06000 for the reliability block, and the first and last words of the control page. A wrong comparison bound therefore shows up as a wrong strobe. Each timer offset is sent with the security bit set and clear, both on the real page and on the alias page. This separates steering by attribute from alias rewriting. Default-space offsets are sent both privileged and unprivileged, which separates read-as-zero from fault. A held response with a pending second request shows whether back-pressure stalls the strobe and freezes the response data.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  // target indices; T_DFLT is the internal responder
  typedef enum logic [2:0] {
    T_SCS     = 3'd0,
    T_TICK_NS = 3'd1,
    T_TICK_S  = 3'd2,
    T_RAS     = 3'd3,
    T_DFLT    = 3'd4
  } tgt_e;

  localparam int NUM_TGT    = 4;
  localparam int LOCAL_W    = 12;
  localparam int SCS_PAGE   = 'h0E;
  localparam int ALIAS_PAGE = 'h2E;
  localparam int TICK_LO    = 'h010;
  localparam int TICK_SIZE  = 'h0E0;
  localparam int RAS_BASE   = 'h05000;
endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter bit SEC_EXT  = 1'b1,
  parameter bit RAS_EN   = 1'b1,
  parameter int RAS_SIZE = 'h1000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              secure,
  output logic [NUM_TGT:0]  hit,
  output logic              fwd_secure
);
  localparam int PAGE_W = ADDR_W - LOCAL_W;

  logic [PAGE_W-1:0]  page;
  logic [LOCAL_W-1:0] lo;
  logic in_scs, in_alias, in_tick, in_ras, sec_tick;

  assign page    = addr[ADDR_W-1:LOCAL_W];
  assign lo      = addr[LOCAL_W-1:0];
  assign in_scs  = (page == PAGE_W'(SCS_PAGE));
  assign in_tick = (lo >= LOCAL_W'(TICK_LO)) && (lo < LOCAL_W'(TICK_LO + TICK_SIZE));

  generate
    if (SEC_EXT) begin : g_sec
      assign in_alias = (page == PAGE_W'(ALIAS_PAGE)) && secure;
      assign sec_tick = secure && !in_alias;
    end else begin : g_nosec
      assign in_alias = 1'b0;
      assign sec_tick = 1'b0;
    end
    if (RAS_EN) begin : g_ras
      assign in_ras = (addr >= ADDR_W'(RAS_BASE)) && (addr < ADDR_W'(RAS_BASE + RAS_SIZE));
    end else begin : g_noras
      assign in_ras = 1'b0;
    end
  endgenerate

  always_comb begin
    hit        = '0;
    fwd_secure = secure && !in_alias;
    if (in_scs || in_alias) begin
      if (in_tick) begin
        if (sec_tick) hit[T_TICK_S]  = 1'b1;
        else          hit[T_TICK_NS] = 1'b1;
      end else begin
        hit[T_SCS] = 1'b1;
      end
    end else if (in_ras) begin
      hit[T_RAS] = 1'b1;
    end else begin
      hit[T_DFLT] = 1'b1;
    end
  end
endmodule

// File: rtl/sysreg_resp.sv
module sysreg_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              dflt,
  input  logic              priv,
  input  logic [DATA_W-1:0] rdata_in,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_fault,
  output logic              can_accept
);
  assign can_accept = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_fault <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= dflt ? '0 : rdata_in;
      rsp_fault <= dflt && !priv;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sysreg_router.sv
module sysreg_router
  import sysreg_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 32,
  parameter bit SEC_EXT  = 1'b1,
  parameter bit RAS_EN   = 1'b1,
  parameter int RAS_SIZE = 'h1000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic                      req_write,
  input  logic [DATA_W-1:0]         req_wdata,
  input  logic                      req_priv,
  input  logic                      req_secure,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [DATA_W-1:0]         rsp_rdata,
  output logic                      rsp_fault,
  output logic [NUM_TGT-1:0]        tgt_sel,
  output logic [LOCAL_W-1:0]        tgt_addr,
  output logic                      tgt_write,
  output logic [DATA_W-1:0]         tgt_wdata,
  output logic                      tgt_secure,
  output logic                      tgt_priv,
  input  logic [NUM_TGT*DATA_W-1:0] tgt_rdata
);
  logic [NUM_TGT:0]  hit;
  logic              fwd_secure, accept, dflt_hit;
  logic [DATA_W-1:0] sel_rdata;

  sysreg_decode #(
    .ADDR_W(ADDR_W), .SEC_EXT(SEC_EXT), .RAS_EN(RAS_EN), .RAS_SIZE(RAS_SIZE)
  ) i_decode (
    .addr(req_addr), .secure(req_secure), .hit(hit), .fwd_secure(fwd_secure)
  );

  assign accept     = req_valid && req_ready;
  assign dflt_hit   = hit[T_DFLT];
  assign tgt_sel    = accept ? hit[NUM_TGT-1:0] : '0;
  assign tgt_addr   = req_addr[LOCAL_W-1:0];
  assign tgt_write  = req_write;
  assign tgt_wdata  = req_wdata;
  assign tgt_secure = fwd_secure;
  assign tgt_priv   = req_priv;

  always_comb begin
    sel_rdata = '0;
    for (int t = 0; t < NUM_TGT; t++) begin
      if (hit[t]) sel_rdata = sel_rdata | tgt_rdata[t*DATA_W +: DATA_W];
    end
  end

  sysreg_resp #(.DATA_W(DATA_W)) i_resp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .dflt(dflt_hit), .priv(req_priv),
    .rdata_in(sel_rdata), .rsp_ready(rsp_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault), .can_accept(req_ready)
  );
endmodule

// File: rtl/sysreg_router_chk.sv
module sysreg_router_chk
  import sysreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_priv,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [DATA_W-1:0]  rsp_rdata,
  input logic               rsp_fault,
  input logic [NUM_TGT-1:0] tgt_sel,
  input logic               tgt_secure,
  input logic               dflt_hit
);
  // R9
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> ($countones({tgt_sel, dflt_hit}) == 1));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |-> (tgt_sel == '0));
  // R5
  secure_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel[T_TICK_S] |-> tgt_secure);
  // R1
  raz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && dflt_hit && req_priv) |=> (rsp_valid && !rsp_fault && rsp_rdata == '0));
  // R2
  fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && dflt_hit && !req_priv) |=> (rsp_valid && rsp_fault));
  // R10
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R11
  hold_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_fault)));
endmodule

bind sysreg_router sysreg_router_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_priv(req_priv), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault), .tgt_sel(tgt_sel),
  .tgt_secure(tgt_secure), .dflt_hit(dflt_hit)
);

// File: tb/test_sysreg_router.sv
module test_sysreg_router;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0, req_secure = 1'b0;
  logic [19:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         req_ready, rsp_valid, rsp_fault, tgt_write, tgt_secure, tgt_priv;
  logic         rsp_ready = 1'b1;
  logic [31:0]  rsp_rdata, tgt_wdata;
  logic [3:0]   tgt_sel;
  logic [11:0]  tgt_addr;
  logic [127:0] tgt_rdata;
  int           n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  sysreg_router i_sysreg_router (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_priv(req_priv), .req_secure(req_secure), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
    .tgt_sel(tgt_sel), .tgt_addr(tgt_addr), .tgt_write(tgt_write),
    .tgt_wdata(tgt_wdata), .tgt_secure(tgt_secure), .tgt_priv(tgt_priv),
    .tgt_rdata(tgt_rdata)
  );

  // stub targets: tag, forwarded attribute, local offset
  always_comb begin
    for (int t = 0; t < 4; t++)
      tgt_rdata[t*32 +: 32] = {8'(8'hA0 + t), 11'h0, tgt_secure, tgt_addr};
  end

  // {addr, write, priv, secure, exp_target(4=default), exp_fault, exp_fwd_secure}
  localparam int NV = 19;
  localparam logic [27:0] VEC [NV] = '{
    {20'h0E00C, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h0E010, 1'b0, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0},
    {20'h0E010, 1'b0, 1'b1, 1'b1, 3'd2, 1'b0, 1'b1},
    {20'h0E0EF, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 1'b1},
    {20'h0E0EF, 1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0},
    {20'h0E0F0, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0, 1'b1},
    {20'h0E000, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0},
    {20'h0EFFC, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0, 1'b1},
    {20'h01000, 1'b0, 1'b1, 1'b0, 3'd4, 1'b0, 1'b0},
    {20'h01000, 1'b1, 1'b1, 1'b1, 3'd4, 1'b0, 1'b0},
    {20'h01000, 1'b0, 1'b0, 1'b0, 3'd4, 1'b1, 1'b0},
    {20'hFFFFC, 1'b1, 1'b0, 1'b1, 3'd4, 1'b1, 1'b0},
    {20'h05004, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0},
    {20'h04FFC, 1'b0, 1'b1, 1'b0, 3'd4, 1'b0, 1'b0},
    {20'h06000, 1'b0, 1'b1, 1'b0, 3'd4, 1'b0, 1'b0},
    {20'h2E010, 1'b0, 1'b1, 1'b1, 3'd1, 1'b0, 1'b0},
    {20'h2E100, 1'b1, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0},
    {20'h2E020, 1'b1, 1'b1, 1'b0, 3'd4, 1'b0, 1'b0},
    {20'h2E020, 1'b0, 1'b0, 1'b0, 3'd4, 1'b1, 1'b0}
  };

  function automatic string tag_of(logic [19:0] a, logic [2:0] t, logic pv);
    if (a[19:12] == 8'h2E) return (t == 3'd4) ? "R7" : "R6";
    case (t)
      3'd0: return "R3";
      3'd1, 3'd2: return "R4 R5";
      3'd3: return "R8";
      default: return pv ? "R1" : "R2";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive one request with response taken; returns strobe-phase samples
  task automatic send(input logic [19:0] a, input logic w, input logic pv, input logic sc,
                      output logic [3:0] sel, output logic [11:0] la, output logic fs);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_priv = pv; req_secure = sc;
    req_wdata = {12'h5A5, a};
    #1;
    sel = tgt_sel; la = tgt_addr; fs = tgt_secure;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] sel;
    logic [11:0] la;
    logic fs;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12", "rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", "rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    check("R12", "req_ready after reset", {31'b0, req_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [19:0] a;
      logic w, pv, sc, ef, es;
      logic [2:0] et;
      logic [3:0] exp_sel;
      logic [31:0] exp_rd;
      string rq;
      {a, w, pv, sc, et, ef, es} = VEC[i];
      rq = tag_of(a, et, pv);
      exp_sel = (et == 3'd4) ? 4'b0 : (4'b1 << et);
      exp_rd  = (et == 3'd4) ? 32'h0 : {8'(8'hA0 + et), 11'h0, es, a[11:0]};
      send(a, w, pv, sc, sel, la, fs);
      check(rq, $sformatf("strobe @%h", a), {28'b0, sel}, {28'b0, exp_sel});
      if (et != 3'd4) begin
        check("R9", $sformatf("local offset @%h", a), {20'b0, la}, {20'b0, a[11:0]});
        check(rq, $sformatf("fwd secure @%h", a), {31'b0, fs}, {31'b0, es});
      end
      check("R10", $sformatf("rsp_valid @%h", a), {31'b0, rsp_valid}, 32'd1);
      check(rq, $sformatf("rdata @%h", a), rsp_rdata, exp_rd);
      check(rq, $sformatf("fault @%h", a), {31'b0, rsp_fault}, {31'b0, ef});
    end

    // response drops once taken and nothing new is accepted
    @(negedge clk);
    check("R11", "rsp drops after take", {31'b0, rsp_valid}, 32'd0);

    // back-pressure: hold a control-page read, offer a timer read behind it
    rsp_ready = 1'b0;
    send(20'h0E100, 1'b0, 1'b1, 1'b0, sel, la, fs);
    check("R10", "held rdata", rsp_rdata, {8'hA0, 11'h0, 1'b0, 12'h100});
    req_valid = 1'b1; req_addr = 20'h0E020; req_write = 1'b1; req_priv = 1'b1; req_secure = 1'b1;
    #1;
    check("R11", "req_ready while held", {31'b0, req_ready}, 32'd0);
    check("R11", "no strobe while held", {28'b0, tgt_sel}, 32'd0);
    @(negedge clk);
    check("R11", "rsp held valid", {31'b0, rsp_valid}, 32'd1);
    check("R11", "rsp held data", rsp_rdata, {8'hA0, 11'h0, 1'b0, 12'h100});
    rsp_ready = 1'b1;
    #1;
    check("R11", "ready on take", {31'b0, req_ready}, 32'd1);
    check("R5", "secure timer strobe on take", {28'b0, tgt_sel}, 32'h4);
    check("R9", "write flag", {31'b0, tgt_write}, 32'd1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    check("R10", "second rsp data", rsp_rdata, {8'hA2, 11'h0, 1'b1, 12'h020});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule